// File: doc/BRIEF.md
# Two-Phase PWM Sequencer

This block is the digital sequencing core of a two-phase, current-mode buck controller. An internal counter marks out oscillator cycles of a set length in system clocks. At each cycle start it raises one of two logic-level phase outputs and hands the on-time to the other phase at the next start, so the outputs strictly alternate. An external current-comparator trip ends the pulse that is running. The counter, the phase pointer and both outputs are registered, and every input acts at the next rising clock edge.

Three protection flags change normal operation. An overvoltage crowbar flag forces both outputs low. A short flag stretches the oscillator cycle to a multiple of its normal length. A feedback-low flag switches a select output from the normal current-limit threshold to the lower foldback threshold. The analog error amplifier, the current sensing and the gate drivers sit outside the block.

Top module: `twophase_pwm_core`

## Requirements
- R1: While reset (`rst_n` low) is held, and right after it, `pwm1_o`, `pwm2_o` and `fold_sel_o` are 0, and the first cycle start after reset drives `pwm1_o`.
- R2: Cycle starts are `BASE_PERIOD` clocks apart while `short_i` is low. The first start raises `pwm1_o` on the `BASE_PERIOD`-th rising edge after reset is released.
- R3: Each cycle start gives the on-time to the other phase, in the order pwm1, pwm2, pwm1 and so on. The start raises that phase's output unless the crowbar is asserted.
- R4: A clock with `trip_i` high and no cycle start drives the active output low at that edge. The output stays low until the next cycle start.
- R5: When `trip_i` and a cycle start fall in the same clock, the old phase ends and the new phase goes high. The trip has no effect on the new pulse.
- R6: `pwm1_o` and `pwm2_o` are never both 1.
- R7: A pulse that is never tripped ends at the next cycle start, so each phase is high for at most one cycle out of two.
- R8: Each rising edge that samples `crowbar_i` high leaves both outputs 0. The outputs stay 0 until the first cycle start that sees `crowbar_i` low. The phase pointer still advances at starts that fall during the crowbar.
- R9: The length of each oscillator cycle is fixed at its start. It is `SLOW_MULT*BASE_PERIOD` clocks if `short_i` is high in the start clock and `BASE_PERIOD` otherwise, so a change of `short_i` takes effect only at a cycle boundary.
- R10: `fold_sel_o` (1 = foldback threshold, 0 = normal current limit) equals the value `fb_low_i` had at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trip_i | input | 1 | Current comparator has reached its threshold |
| crowbar_i | input | 1 | Output overvoltage; forces both phases off |
| fb_low_i | input | 1 | Feedback below the foldback level |
| short_i | input | 1 | Output near zero; slows the oscillator |
| pwm1_o | output | 1 | Phase one logic output |
| pwm2_o | output | 1 | Phase two logic output |
| fold_sel_o | output | 1 | 1 selects the foldback current threshold |

## Verification
The bench aims trips at the exact clock of a cycle start. A design that let such a trip clear the new pulse would show a missing phase pulse there. A design that ignored the start would keep the old phase high. The bench raises the short flag in the middle of a cycle, and a design that reloaded the length at once would put the next start at the wrong clock. Crowbar bursts are placed across cycle starts: a design that froze the phase pointer would restart on the wrong output, and one that raised a pulse after release, without waiting for a start, would show a high output too early. Random trips, folds and shorts are checked every clock against a cycle model kept in the bench.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } phase_e;

  // Oscillator cycle length in clocks for a given short-flag state.
  function automatic int unsigned cycle_len(input int unsigned base,
                                            input int unsigned slow,
                                            input logic        stretched);
    return stretched ? base * slow : base;
  endfunction

  function automatic phase_e other_phase(input phase_e p);
    return (p == PH_ONE) ? PH_TWO : PH_ONE;
  endfunction

endpackage

// File: rtl/tpc_tick_gen.sv
module tpc_tick_gen #(
  parameter int unsigned BASE_PERIOD = 8,
  parameter int unsigned SLOW_MULT   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_i,
  output logic tick_o
);
  import tpc_pkg::*;

  localparam int unsigned MAX_LEN = BASE_PERIOD * SLOW_MULT;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] LEN_NORM = CW'(cycle_len(BASE_PERIOD, SLOW_MULT, 1'b0));
  localparam logic [CW-1:0] LEN_SLOW = CW'(cycle_len(BASE_PERIOD, SLOW_MULT, 1'b1));

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  logic          last_clk;

  assign last_clk = (cnt_q == len_q - 1'b1);
  assign tick_o   = last_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LEN_NORM;
    end else if (last_clk) begin
      cnt_q <= '0;
      len_q <= short_i ? LEN_SLOW : LEN_NORM;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9: cycle length only changes at a boundary
  a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(len_q));

  // R9: length is one of the two legal values
  a_r9_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == LEN_NORM) || (len_q == LEN_SLOW));

  // R2: counter never runs past the cycle length
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

  initial begin
    assert (BASE_PERIOD >= 4) else $error("BASE_PERIOD below 4");
  end

endmodule

// File: rtl/tpc_phase_seq.sv
module tpc_phase_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic trip_i,
  input  logic crowbar_i,
  output logic pwm1_o,
  output logic pwm2_o
);
  import tpc_pkg::*;

  phase_e sel_q;
  logic   p1_q, p2_q;
  logic   p1_d, p2_d;

  always_comb begin
    if (crowbar_i) begin
      p1_d = 1'b0;
      p2_d = 1'b0;
    end else if (start_i) begin
      p1_d = (sel_q == PH_ONE);
      p2_d = (sel_q == PH_TWO);
    end else begin
      p1_d = p1_q & ~trip_i;
      p2_d = p2_q & ~trip_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= PH_ONE;
      p1_q  <= 1'b0;
      p2_q  <= 1'b0;
    end else begin
      if (start_i) sel_q <= other_phase(sel_q);
      p1_q <= p1_d;
      p2_q <= p2_d;
    end
  end

  assign pwm1_o = p1_q;
  assign pwm2_o = p2_q;

  // R6: phases mutually exclusive
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm1_o && pwm2_o));

  // R4: a trip away from a start clears both outputs
  a_r4_trip_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_i && !start_i) |=> !(pwm1_o || pwm2_o));

  // R8: crowbar forces both low
  a_r8_crowbar: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar_i |=> !(pwm1_o || pwm2_o));

  // R3: an output only rises at a cycle start
  a_r3_rise_at_start1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm1_o) |-> $past(start_i));
  a_r3_rise_at_start2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm2_o) |-> $past(start_i));

  // R5: start without crowbar always yields exactly one high output
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !crowbar_i) |=> $onehot0({pwm1_o, pwm2_o}) && (pwm1_o || pwm2_o));

endmodule

// File: rtl/tpc_limit_sel.sv
module tpc_limit_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_low_i,
  output logic fold_sel_o
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= fb_low_i;
  end

  assign fold_sel_o = sel_q;

  // R10: select follows the feedback-low flag one clock later
  a_r10_fold_follow: assert property (@(posedge clk) disable iff (!rst_n)
    fb_low_i |=> fold_sel_o);
  a_r10_fold_release: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_low_i |=> !fold_sel_o);

endmodule

// File: rtl/twophase_pwm_core.sv
module twophase_pwm_core #(
  parameter int unsigned BASE_PERIOD = 8,
  parameter int unsigned SLOW_MULT   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic crowbar_i,
  input  logic fb_low_i,
  input  logic short_i,
  output logic pwm1_o,
  output logic pwm2_o,
  output logic fold_sel_o
);

  logic cycle_start;

  tpc_tick_gen #(
    .BASE_PERIOD(BASE_PERIOD),
    .SLOW_MULT  (SLOW_MULT)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .short_i(short_i),
    .tick_o (cycle_start)
  );

  tpc_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cycle_start),
    .trip_i   (trip_i),
    .crowbar_i(crowbar_i),
    .pwm1_o   (pwm1_o),
    .pwm2_o   (pwm2_o)
  );

  tpc_limit_sel u_lim (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_low_i  (fb_low_i),
    .fold_sel_o(fold_sel_o)
  );

  // R7: no output stays high across a cycle start
  a_r7_no_carry1: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && pwm1_o) |=> !pwm1_o);
  a_r7_no_carry2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && pwm2_o) |=> !pwm2_o);

endmodule

// File: tb/twophase_pwm_core_test.sv
module twophase_pwm_core_test;
  localparam int NP = 8;
  localparam int SF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, crow = 1'b0, fbl = 1'b0, shrt = 1'b0;
  logic pwm1, pwm2, fold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  twophase_pwm_core #(.BASE_PERIOD(NP), .SLOW_MULT(SF)) uut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .crowbar_i(crow),
    .fb_low_i(fbl), .short_i(shrt),
    .pwm1_o(pwm1), .pwm2_o(pwm2), .fold_sel_o(fold)
  );

  always #2 clk = ~clk;

  // Behavioural model built from the requirements
  int m_cnt, m_len;
  bit m_sel, m_a, m_b, m_f, m_tk;

  function automatic int exp_len(bit s);
    return s ? NP * SF : NP;
  endfunction

  function automatic bit start_next();
    return (m_cnt == m_len - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_len = NP; m_sel = 0; m_a = 0; m_b = 0; m_f = 0;
    end else begin
      m_tk = (m_cnt == m_len - 1);
      m_f  = fbl;
      if (crow) begin
        m_a = 0; m_b = 0;
      end else if (m_tk) begin
        m_a = (m_sel == 0); m_b = (m_sel == 1);
      end else begin
        m_a = m_a & ~trip; m_b = m_b & ~trip;
      end
      if (m_tk) begin
        m_cnt = 0; m_len = exp_len(shrt); m_sel = ~m_sel;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3/R4/R5/R7/R8/R9 pwm1", pwm1, m_a);
    check("R3/R4/R5/R7/R8/R9 pwm2", pwm2, m_b);
    check("R10 fold_sel", fold, m_f);
    check("R6 exclusive", pwm1 & pwm2, 1'b0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pwm1 reset", pwm1, 1'b0);
    check("R1 pwm2 reset", pwm2, 1'b0);
    check("R1 fold reset", fold, 1'b0);
    rst_n = 1'b1;
    // R2: first start on the NP-th edge, driving pwm1 (R1)
    for (int i = 1; i < NP; i++) begin
      @(negedge clk);
      check("R2 no early start", pwm1 | pwm2, 1'b0);
    end
    @(negedge clk);
    check("R1 first phase pwm1", pwm1, 1'b1);
    check("R2 start timing", pwm2, 1'b0);
    // R7: untripped pulse runs to next start then hands over (R3)
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      compare_all();
    end
    check("R3 second phase pwm2", pwm2, 1'b1);
    check("R7 pwm1 ended", pwm1, 1'b0);
    // R5: trip aimed at start clocks
    for (int i = 0; i < 6 * NP; i++) begin
      trip = start_next();
      @(negedge clk);
      compare_all();
      if (trip) check("R5 new pulse kept", pwm1 | pwm2, 1'b1);
    end
    trip = 0;
    // R9: raise short mid cycle, hold for a few slow cycles, then drop mid cycle
    while (m_cnt != 2) begin @(negedge clk); compare_all(); end
    shrt = 1'b1;
    for (int i = 0; i < 4 * NP * SF; i++) begin @(negedge clk); compare_all(); end
    shrt = 1'b0;
    for (int i = 0; i < 3 * NP * SF; i++) begin @(negedge clk); compare_all(); end
    // R8: crowbar across a start
    while (!start_next()) begin @(negedge clk); compare_all(); end
    crow = 1'b1;
    for (int i = 0; i < NP + 3; i++) begin
      @(negedge clk); compare_all();
      check("R8 both low", pwm1 | pwm2, 1'b0);
    end
    crow = 1'b0;
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int cb_left;
      trip = ($urandom % 6) == 0;
      fbl  = ($urandom % 4) == 0 ? ~fbl : fbl;
      if (($urandom % 150) == 0) shrt = ~shrt;
      if (($urandom % 120) == 0) begin
        cb_left = 1 + $urandom % 20;
        crow = 1'b1;
        for (int k = 0; k < cb_left; k++) begin
          trip = ($urandom % 6) == 0;
          @(negedge clk); compare_all();
        end
        crow = 1'b0;
      end
      @(negedge clk);
      compare_all();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule